// File: doc/BRIEF.md
# Interlace-Aware Display Timing Generator

This block produces the control signals for a parallel pixel display: horizontal sync, vertical sync, data enable, and flags that say which field and which eye is being scanned. It also gives the column and row of the current active pixel. One horizontal timing is shared by every line. Vertical timing comes from four separate sets, one per field kind, and each set has its own sync length, back porch, front porch and half-line shift flag. This lets a single generator drive progressive, interlaced, stereo 3D, and interlaced stereo modes.

Software holds the soft reset, writes the configuration, then releases the reset and scanning starts at the origin. The configuration is copied into shadow registers while the soft reset is held and again at each frame boundary, so a write made during a frame takes effect only at the next frame. In interlaced modes the programmed active height applies to each field, which means it is half the frame height. Set index bit 0 marks an even field and bit 1 marks the right eye: set 0 is left-odd, 1 is left-even, 2 is right-odd and 3 is right-even.

Top module: `vid_timing_gen`

## Requirements
- R1: While softRst is high, each clock edge puts the scan at the origin: pixel 0 of line 0 in set 0, with de low, xPos and yPos zero, field and eye low. Each of those edges also loads the configuration into the shadow registers. Sync lengths must be at least 1.
- R2: A line lasts hSyncLen+hBackLen+hActiveLen+hFrontLen pixels. The horizontal sync is active for the first hSyncLen pixels, followed in order by back porch, active pixels and front porch.
- R3: A field lasts vSyncLen+vBackLen+vActiveLen+vFrontLen lines, using the lengths of the current set. When that set's half-line flag is clear, the vertical sync is active for the whole of lines 0 through vSyncLen-1.
- R4: When the current set's half-line flag is set, both vertical sync edges move to pixel floor(lineLength/2). The sync is then active from that pixel of line 0 up to, but not including, that pixel of line vSyncLen.
- R5: de is high only when the pixel lies inside both the horizontal and the vertical active region. Inside that region, xPos and yPos give the pixel offset from the region's start. Outside it, both are zero.
- R6: With interlace on and stereo off, fields run through sets 0,1,0,1,… The field output is 1 in even fields and eye stays 0.
- R7: With both interlace and stereo on, fields run through sets 0,1,2,3,0,… The field output equals set bit 0 and eye equals set bit 1.
- R8: With stereo on and interlace off, fields run through sets 0,2,0,2,… field stays 0 and eye is 1 in right fields.
- R9: With both interlace and stereo off, every field uses set 0, and field and eye stay 0.
- R10: hsActLow and vsActLow invert their own sync output independently. When a bit is set, the active level of that sync is 0.
- R11: A configuration change made during a frame has no effect until the frame ends. The shadow is reloaded on the edge that ends the last field of the sequence, and the new values apply from the first pixel of the next frame.
- R12: The field and eye outputs change on the edge that ends a field, so they take their new value at pixel 0 of line 0 of the new field, which is where that field's vertical sync timing starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous hold at origin, loads shadow config |
| hSyncLen | input | CW | Horizontal sync length in pixels |
| hBackLen | input | CW | Horizontal back porch in pixels |
| hActiveLen | input | CW | Active pixels per line |
| hFrontLen | input | CW | Horizontal front porch in pixels |
| vActiveLen | input | CW | Active lines per field |
| vSyncLen | input | 4×CW | Vertical sync lines, one entry per set |
| vBackLen | input | 4×CW | Vertical back porch lines, one entry per set |
| vFrontLen | input | 4×CW | Vertical front porch lines, one entry per set |
| vHalfShift | input | 4 | Half-line shift flag, one bit per set |
| interlaceEn | input | 1 | Interlaced field sequencing |
| stereoEn | input | 1 | Left/right eye sequencing |
| hsActLow | input | 1 | Horizontal sync active-low |
| vsActLow | input | 1 | Vertical sync active-low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field | output | 1 | 1 during even fields |
| eye | output | 1 | 1 during right-eye fields |
| xPos | output | CW | Active column |
| yPos | output | CW | Active row |

## Verification
The outputs are decoded without a register stage from the scan counters and the set index, so the values for a scan position appear in the cycle after the edge that moved the counters to that position. Configuration therefore has a latency of exactly one frame boundary. The bench keeps a pixel-by-pixel arithmetic model of the scan position and the shadow copy. Inputs change on the falling edge and the model steps once for each rising edge, and every output is compared on the falling edge that follows. Sweeps cover all four sequencing modes with mixed polarities, a soft reset hold, and a write made in the middle of a frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int NUM_SETS = 4;
  localparam int SEL_W    = $clog2(NUM_SETS);

  typedef struct packed {
    logic             clear;
    logic [SEL_W-1:0] setSel;
  } vtgStrobe_t;

  typedef struct packed {
    logic lineEnd;
    logic fieldEnd;
  } vtgStatus_t;

  // Set index: bit0 = even field, bit1 = right eye
  function automatic logic [SEL_W-1:0] nextSet(input logic [SEL_W-1:0] cur,
                                               input logic ilace,
                                               input logic stereo);
    logic [SEL_W-1:0] n;
    case ({stereo, ilace})
      2'b11:   n = cur + 2'd1;
      2'b01:   n = {1'b0, ~cur[0]};
      2'b10:   n = {~cur[1], 1'b0};
      default: n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl import vtg_pkg::*; #(
  parameter int CW = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          softRst,
  input  logic [CW-1:0]                 hSyncIn,
  input  logic [CW-1:0]                 hBackIn,
  input  logic [CW-1:0]                 hActiveIn,
  input  logic [CW-1:0]                 hFrontIn,
  input  logic [CW-1:0]                 vActiveIn,
  input  logic [NUM_SETS-1:0][CW-1:0]   vSyncIn,
  input  logic [NUM_SETS-1:0][CW-1:0]   vBackIn,
  input  logic [NUM_SETS-1:0][CW-1:0]   vFrontIn,
  input  logic [NUM_SETS-1:0]           vHalfIn,
  input  logic                          ilaceIn,
  input  logic                          stereoIn,
  input  logic                          hsLowIn,
  input  logic                          vsLowIn,
  input  vtgStatus_t                    stat,
  output vtgStrobe_t                    strb,
  output logic [CW-1:0]                 shHSync,
  output logic [CW-1:0]                 shHBack,
  output logic [CW-1:0]                 shHActive,
  output logic [CW-1:0]                 shHFront,
  output logic [CW-1:0]                 shVActive,
  output logic [NUM_SETS-1:0][CW-1:0]   shVSync,
  output logic [NUM_SETS-1:0][CW-1:0]   shVBack,
  output logic [NUM_SETS-1:0][CW-1:0]   shVFront,
  output logic [NUM_SETS-1:0]           shVHalf,
  output logic                          shHsLow,
  output logic                          shVsLow,
  output logic                          fieldEven,
  output logic                          eyeRight
);
  logic [SEL_W-1:0] curSel;
  logic [SEL_W-1:0] nxtSel;
  logic             shIlace;
  logic             shStereo;
  logic             loadShadow;

  always_comb begin
    nxtSel     = nextSet(curSel, shIlace, shStereo);
    loadShadow = softRst | (stat.fieldEnd && (nxtSel == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              curSel <= '0;
    else if (softRst)        curSel <= '0;
    else if (stat.fieldEnd)  curSel <= nxtSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shHSync   <= '0;
      shHBack   <= '0;
      shHActive <= '0;
      shHFront  <= '0;
      shVActive <= '0;
      shIlace   <= 1'b0;
      shStereo  <= 1'b0;
      shHsLow   <= 1'b0;
      shVsLow   <= 1'b0;
    end else if (loadShadow) begin
      shHSync   <= hSyncIn;
      shHBack   <= hBackIn;
      shHActive <= hActiveIn;
      shHFront  <= hFrontIn;
      shVActive <= vActiveIn;
      shIlace   <= ilaceIn;
      shStereo  <= stereoIn;
      shHsLow   <= hsLowIn;
      shVsLow   <= vsLowIn;
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shVSync[s]  <= '0;
        shVBack[s]  <= '0;
        shVFront[s] <= '0;
        shVHalf[s]  <= 1'b0;
      end else if (loadShadow) begin
        shVSync[s]  <= vSyncIn[s];
        shVBack[s]  <= vBackIn[s];
        shVFront[s] <= vFrontIn[s];
        shVHalf[s]  <= vHalfIn[s];
      end
    end
  end

  always_comb begin
    strb.clear  = softRst;
    strb.setSel = curSel;
    fieldEven   = curSel[0];
    eyeRight    = curSel[1];
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath import vtg_pkg::*; #(
  parameter int CW = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  vtgStrobe_t                  strb,
  input  logic [CW-1:0]               hSync,
  input  logic [CW-1:0]               hBack,
  input  logic [CW-1:0]               hActive,
  input  logic [CW-1:0]               hFront,
  input  logic [CW-1:0]               vActive,
  input  logic [NUM_SETS-1:0][CW-1:0] vSync,
  input  logic [NUM_SETS-1:0][CW-1:0] vBack,
  input  logic [NUM_SETS-1:0][CW-1:0] vFront,
  input  logic [NUM_SETS-1:0]         vHalf,
  input  logic                        hsLow,
  input  logic                        vsLow,
  output vtgStatus_t                  stat,
  output logic                        hsync,
  output logic                        vsync,
  output logic                        de,
  output logic [CW-1:0]               xPos,
  output logic [CW-1:0]               yPos
);
  localparam int TW = CW + 2;

  logic [TW-1:0] hCount, vCount;
  logic [TW-1:0] hTotal, vTotal, hActLo, hActHi, vActLo, vActHi, hMid, selSync;
  logic          hsOn, vsOn, deH, deV;

  always_comb begin
    hTotal  = TW'(hSync) + TW'(hBack) + TW'(hActive) + TW'(hFront);
    hActLo  = TW'(hSync) + TW'(hBack);
    hActHi  = hActLo + TW'(hActive);
    selSync = TW'(vSync[strb.setSel]);
    vActLo  = selSync + TW'(vBack[strb.setSel]);
    vActHi  = vActLo + TW'(vActive);
    vTotal  = vActHi + TW'(vFront[strb.setSel]);
    hMid    = vHalf[strb.setSel] ? (hTotal >> 1) : '0;

    stat.lineEnd  = (hCount == hTotal - TW'(1));
    stat.fieldEnd = stat.lineEnd && (vCount == vTotal - TW'(1));

    hsOn = (hCount < TW'(hSync));
    vsOn = ((vCount != '0) || (hCount >= hMid)) &&
           ((vCount < selSync) || ((vCount == selSync) && (hCount < hMid)));
    deH  = (hCount >= hActLo) && (hCount < hActHi);
    deV  = (vCount >= vActLo) && (vCount < vActHi);

    hsync = hsOn ^ hsLow;
    vsync = vsOn ^ vsLow;
    de    = deH && deV;
    xPos  = de ? CW'(hCount - hActLo) : '0;
    yPos  = de ? CW'(vCount - vActLo) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strb.clear) begin
      hCount <= '0;
      vCount <= '0;
    end else if (stat.lineEnd) begin
      hCount <= '0;
      vCount <= stat.fieldEnd ? '0 : vCount + TW'(1);
    end else begin
      hCount <= hCount + TW'(1);
    end
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen import vtg_pkg::*; #(
  parameter int CW = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        softRst,
  input  logic [CW-1:0]               hSyncLen,
  input  logic [CW-1:0]               hBackLen,
  input  logic [CW-1:0]               hActiveLen,
  input  logic [CW-1:0]               hFrontLen,
  input  logic [CW-1:0]               vActiveLen,
  input  logic [3:0][CW-1:0]          vSyncLen,
  input  logic [3:0][CW-1:0]          vBackLen,
  input  logic [3:0][CW-1:0]          vFrontLen,
  input  logic [3:0]                  vHalfShift,
  input  logic                        interlaceEn,
  input  logic                        stereoEn,
  input  logic                        hsActLow,
  input  logic                        vsActLow,
  output logic                        hsync,
  output logic                        vsync,
  output logic                        de,
  output logic                        field,
  output logic                        eye,
  output logic [CW-1:0]               xPos,
  output logic [CW-1:0]               yPos
);
  vtgStrobe_t                  strb;
  vtgStatus_t                  stat;
  logic [CW-1:0]               shHSync, shHBack, shHActive, shHFront, shVActive;
  logic [NUM_SETS-1:0][CW-1:0] shVSync, shVBack, shVFront;
  logic [NUM_SETS-1:0]         shVHalf;
  logic                        shHsLow, shVsLow;

  vtg_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .softRst(softRst),
    .hSyncIn(hSyncLen), .hBackIn(hBackLen), .hActiveIn(hActiveLen),
    .hFrontIn(hFrontLen), .vActiveIn(vActiveLen),
    .vSyncIn(vSyncLen), .vBackIn(vBackLen), .vFrontIn(vFrontLen),
    .vHalfIn(vHalfShift), .ilaceIn(interlaceEn), .stereoIn(stereoEn),
    .hsLowIn(hsActLow), .vsLowIn(vsActLow),
    .stat(stat), .strb(strb),
    .shHSync(shHSync), .shHBack(shHBack), .shHActive(shHActive),
    .shHFront(shHFront), .shVActive(shVActive),
    .shVSync(shVSync), .shVBack(shVBack), .shVFront(shVFront),
    .shVHalf(shVHalf), .shHsLow(shHsLow), .shVsLow(shVsLow),
    .fieldEven(field), .eyeRight(eye)
  );

  vtg_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hSync(shHSync), .hBack(shHBack), .hActive(shHActive), .hFront(shHFront),
    .vActive(shVActive), .vSync(shVSync), .vBack(shVBack), .vFront(shVFront),
    .vHalf(shVHalf), .hsLow(shHsLow), .vsLow(shVsLow),
    .stat(stat), .hsync(hsync), .vsync(vsync), .de(de),
    .xPos(xPos), .yPos(yPos)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          softRst,
  input logic          de,
  input logic          field,
  input logic          eye,
  input logic [CW-1:0] xPos,
  input logic [CW-1:0] yPos
);
  AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> (!de && xPos == '0 && yPos == '0 && !field && !eye)); // R1

  AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> (xPos == '0)); // R5

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de)) |-> (xPos == $past(xPos) + CW'(1))); // R5

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de)) |-> (yPos == $past(yPos))); // R5

  AST_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({eye, field}) |-> !de); // R12
endmodule

bind vid_timing_gen vtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .softRst(softRst), .de(de),
  .field(field), .eye(eye), .xPos(xPos), .yPos(yPos)
);

// File: tb/tb_vid_timing_gen.sv
module tb_vid_timing_gen;
  localparam int CW = 12;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, softRst;
  logic [CW-1:0] hSyncLen, hBackLen, hActiveLen, hFrontLen, vActiveLen;
  logic [3:0][CW-1:0] vSyncLen, vBackLen, vFrontLen;
  logic [3:0] vHalfShift;
  logic interlaceEn, stereoEn, hsActLow, vsActLow;
  logic hsync, vsync, de, field, eye;
  logic [CW-1:0] xPos, yPos;

  vid_timing_gen #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .softRst(softRst),
    .hSyncLen(hSyncLen), .hBackLen(hBackLen), .hActiveLen(hActiveLen),
    .hFrontLen(hFrontLen), .vActiveLen(vActiveLen),
    .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vFrontLen(vFrontLen),
    .vHalfShift(vHalfShift), .interlaceEn(interlaceEn), .stereoEn(stereoEn),
    .hsActLow(hsActLow), .vsActLow(vsActLow),
    .hsync(hsync), .vsync(vsync), .de(de), .field(field), .eye(eye),
    .xPos(xPos), .yPos(yPos)
  );

  int checks = 0;
  int fails  = 0;
  string phaseTag = "";

  // model state and its shadow of the configuration
  int mh = 0, mv = 0, msel = 0;
  int sHs, sHb, sHa, sHf, sVa;
  int sVs[4], sVb[4], sVf[4];
  bit sHalf[4];
  bit sIl, sSt, sHl, sVl;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic loadShadow();
    sHs = int'(hSyncLen); sHb = int'(hBackLen); sHa = int'(hActiveLen);
    sHf = int'(hFrontLen); sVa = int'(vActiveLen);
    for (int s = 0; s < 4; s++) begin
      sVs[s] = int'(vSyncLen[s]); sVb[s] = int'(vBackLen[s]);
      sVf[s] = int'(vFrontLen[s]); sHalf[s] = vHalfShift[s];
    end
    sIl = interlaceEn; sSt = stereoEn; sHl = hsActLow; sVl = vsActLow;
  endtask

  function automatic int nxt(input int s);
    if (sIl && sSt) return (s + 1) % 4;
    if (sIl)        return (s == 0) ? 1 : 0;
    if (sSt)        return (s == 0) ? 2 : 0;
    return 0;
  endfunction

  task automatic modelStep();
    int hT, vT, n;
    if (softRst) begin
      mh = 0; mv = 0; msel = 0;
      loadShadow();
    end else begin
      hT = sHs + sHb + sHa + sHf;
      vT = sVs[msel] + sVb[msel] + sVa + sVf[msel];
      if (mh == hT - 1) begin
        mh = 0;
        if (mv == vT - 1) begin
          mv = 0;
          n = nxt(msel);
          msel = n;
          if (n == 0) loadShadow();
        end else mv++;
      end else mh++;
    end
  endtask

  task automatic compare();
    int hT, vs, vb, hMid, ex, ey, eHs, eVs;
    bit eDe, hOn, vOn;
    string tH, tV, tD, tF;
    hT   = sHs + sHb + sHa + sHf;
    vs   = sVs[msel]; vb = sVb[msel];
    hMid = sHalf[msel] ? hT / 2 : 0;
    hOn  = (mh < sHs);
    vOn  = ((mv != 0) || (mh >= hMid)) && ((mv < vs) || ((mv == vs) && (mh < hMid)));
    eDe  = (mh >= sHs + sHb) && (mh < sHs + sHb + sHa) &&
           (mv >= vs + vb) && (mv < vs + vb + sVa);
    ex   = eDe ? mh - (sHs + sHb) : 0;
    ey   = eDe ? mv - (vs + vb) : 0;
    eHs  = int'(hOn ^ sHl);
    eVs  = int'(vOn ^ sVl);
    tH = sHl ? "R10" : "R2";
    tV = sVl ? "R10" : (sHalf[msel] ? "R4" : "R3");
    tD = "R5";
    case ({sSt, sIl})
      2'b01:   tF = "R6";
      2'b11:   tF = "R7";
      2'b10:   tF = "R8";
      default: tF = "R9";
    endcase
    if (mh == 0 && mv == 0) tF = "R12";
    if (phaseTag != "") begin tH = phaseTag; tV = phaseTag; tD = phaseTag; tF = phaseTag; end
    chk(int'(hsync) == eHs, tH, "hsync", int'(hsync), eHs);
    chk(int'(vsync) == eVs, tV, "vsync", int'(vsync), eVs);
    chk(de == eDe, tD, "de", int'(de), int'(eDe));
    chk(int'(xPos) == ex, tD, "xPos", int'(xPos), ex);
    chk(int'(yPos) == ey, tD, "yPos", int'(yPos), ey);
    chk(int'(field) == (msel & 1), tF, "field", int'(field), msel & 1);
    chk(int'(eye) == (msel >> 1), tF, "eye", int'(eye), msel >> 1);
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic setBase();
    hSyncLen = CW'(2); hBackLen = CW'(3); hActiveLen = CW'(8); hFrontLen = CW'(3);
    vActiveLen = CW'(4);
    vSyncLen[0] = CW'(2); vBackLen[0] = CW'(2); vFrontLen[0] = CW'(2);
    vSyncLen[1] = CW'(3); vBackLen[1] = CW'(1); vFrontLen[1] = CW'(2);
    vSyncLen[2] = CW'(1); vBackLen[2] = CW'(3); vFrontLen[2] = CW'(1);
    vSyncLen[3] = CW'(2); vBackLen[3] = CW'(1); vFrontLen[3] = CW'(3);
    vHalfShift = 4'b1010;
  endtask

  task automatic startRun(input bit il, input bit st, input bit hl, input bit vl);
    softRst = 1'b1;
    setBase();
    interlaceEn = il; stereoEn = st; hsActLow = hl; vsActLow = vl;
    phaseTag = "R1";
    repeat (3) tick();
    softRst = 1'b0;
    phaseTag = "";
  endtask

  initial begin
    rst_n = 1'b0; softRst = 1'b1;
    setBase();
    interlaceEn = 1'b0; stereoEn = 1'b0; hsActLow = 1'b0; vsActLow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: origin state while the soft reset is held
    phaseTag = "R1";
    repeat (4) tick();
    phaseTag = "";
    // R2..R10, R12: sweep of all sequencing modes with polarity variants
    for (int r = 0; r < 8; r++) begin
      startRun(r[0], r[1], r[2], ~r[2]);
      repeat (1300) tick();
    end
    // R1: soft reset asserted in the middle of a frame
    startRun(1'b1, 1'b1, 1'b0, 1'b0);
    repeat (300) tick();
    startRun(1'b1, 1'b1, 1'b1, 1'b1);
    repeat (200) tick();
    // R11: write in the middle of a frame applies at the next frame only
    startRun(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (200) tick();
    phaseTag = "R11";
    hActiveLen = CW'(6); vActiveLen = CW'(3); vHalfShift = 4'b0000;
    interlaceEn = 1'b0; stereoEn = 1'b1; hsActLow = 1'b1;
    repeat (1300) tick();
    phaseTag = "";
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule